// File: doc/BRIEF.md
# Interrupt Acceptance and Exception-Entry Sequencer

This block sits between the interrupt sources of a processor core and its memory port. It watches one non-maskable request and a parameterised set of maskable sources, each carrying a 4-bit priority level. When a request may be taken, it picks a single winner and reports it on a one-cycle `take` strobe. The source is expected to drop its request once it sees that strobe. The block then steps through a fixed-latency acceptance pipeline before it runs the memory accesses that enter the exception handler.

The latency of the acceptance pipeline depends on the class of the winning source. External IRQ lines, and peripherals that can start a DMA transfer, spend one cycle in a DMA-activation judgment stage. The non-maskable line and the other peripherals skip that stage. Priority judgment then takes three cycles for IRQ lines and two cycles for the other classes. Next the block waits for the core to signal that its current sequence is complete. Entry then costs five fixed cycles plus the wait states of three longword accesses: the status word is saved, the program counter is saved, and the vector is read. Finally the block issues the fetch of the first handler instruction from the address it read back.

A latency counter counts every busy cycle before the fetch begins. It freezes when the fetch starts, so the cycle count from acceptance to handler fetch can be read directly.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `take` and `mem_req` are 0 and `lat_cycles` is 0.
- R2: A maskable source is eligible only while its request is high and its level is strictly greater than `sr_mask`. With no eligible source and no non-maskable request, `take` stays 0 and the block stays idle.
- R3: The non-maskable request acts as level 16. It is always accepted and beats every maskable source, and `take_src` then reads NSRC (4 by default).
- R4: Among eligible maskable sources the highest level wins. Equal levels go to the lowest source index.
- R5: For the non-maskable line and for peripherals, `lat_cycles` at handler-fetch start equals D + 2 + X + 5 + m1 + m2 + m3. D is 1 for a DMA-capable peripheral (source 2 by default) and 0 otherwise. X is the wait for `cpu_done`, and m1, m2 and m3 are the cycles of each access. With X = 0 and single-cycle accesses this gives 10 for the non-maskable line.
- R6: For IRQ sources (sources 0 and 1 by default), D = 1 and priority judgment takes 3 cycles, which gives a minimum of 12.
- R7: After the last priority cycle, the block holds for as many cycles as `cpu_done` is sampled low, counting from that last priority cycle onward.
- R8: Entry accesses follow a fixed order. First a write of `sr_in` to `sp_in`-4 (kind 0). Then a write of `pc_in` to `sp_in`-8 (kind 1). Then a read of `vbr_in`+4×vector (kind 2). The vector is 11 for the non-maskable line and 64+index for source *index*. One fixed cycle precedes each of the three accesses, and two fixed cycles follow the read.
- R9: The handler fetch (kind 3, read) uses the longword returned by the vector read as its address. It lasts m4 cycles, and the block is idle in the cycle after the fetch's `mem_ready`.
- R10: An access keeps `mem_req`, `mem_addr` and `mem_kind` steady until `mem_ready` is sampled high.
- R11: `lat_cycles` stays unchanged from handler-fetch start until the next acceptance. It restarts from 0 on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request |
| src_req | input | NSRC | Maskable request per source |
| src_level | input | NSRC*4 | Priority level per source, source i in bits [4i+3:4i] |
| sr_mask | input | 4 | Current interrupt mask level |
| sr_in | input | 32 | Status word to save |
| pc_in | input | 32 | Return address to save |
| sp_in | input | 32 | Stack pointer for the saves |
| vbr_in | input | 32 | Vector table base |
| cpu_done | input | 1 | Core has finished its current sequence |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_kind | output | 2 | 0 SR save, 1 PC save, 2 vector read, 3 handler fetch |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| take | output | 1 | Request accepted this cycle |
| take_src | output | SRCW | Accepted source, NSRC for non-maskable |
| busy | output | 1 | Sequencer active |
| lat_cycles | output | CNTW | Busy cycles before handler fetch start |

## Verification
A state register that is wrong shows up at the memory port or on `busy` within one cycle of the point where its stage should end. A stage that runs one cycle too long or too short moves every later access by that amount, and it leaves a different `lat_cycles` at fetch start. A wrong winner or vector register shows up as a wrong vector-read address, and a corrupted saved handler shows up as a wrong fetch address. For these reasons the bench compares every output on every busy cycle against a timeline built from the chosen wait states.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int LVLW = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DMA, ST_PRI, ST_WAIT,
        ST_E0, ST_SRW, ST_E1, ST_PCW, ST_E2, ST_VRD, ST_E3, ST_E4, ST_FET
    } seq_state_e;

    typedef enum logic [1:0] {
        K_SR    = 2'd0,
        K_PC    = 2'd1,
        K_VEC   = 2'd2,
        K_FETCH = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/irq_entry_pick.sv
module irq_entry_pick #(
    parameter int NSRC = 4,
    parameter int LVLW = 4,
    parameter int SRCW = $clog2(NSRC + 1)
) (
    input  logic                 nmi_req,
    input  logic [NSRC-1:0]      src_req,
    input  logic [NSRC*LVLW-1:0] src_level,
    input  logic [LVLW-1:0]      mask,
    output logic                 pick_valid,
    output logic [SRCW-1:0]      pick_src
);
    logic [NSRC-1:0] elig;
    logic [LVLW-1:0] lvl [NSRC];
    logic [LVLW-1:0] best;
    logic            found;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign lvl[g]  = src_level[g*LVLW +: LVLW];
        assign elig[g] = src_req[g] && (lvl[g] > mask);
    end

    always_comb begin
        found    = 1'b0;
        best     = '0;
        pick_src = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || lvl[i] > best)) begin
                found    = 1'b1;
                best     = lvl[i];
                pick_src = SRCW'(i);
            end
        end
        if (nmi_req) pick_src = SRCW'(NSRC);
        pick_valid = nmi_req || found;
    end
endmodule

// File: rtl/irq_entry_cost.sv
module irq_entry_cost #(
    parameter int              NSRC     = 4,
    parameter int              SRCW     = $clog2(NSRC + 1),
    parameter int              VECW     = 8,
    parameter logic [NSRC-1:0] IRQ_SET  = 4'b0011,
    parameter logic [NSRC-1:0] DMA_SET  = 4'b0100,
    parameter int              NMI_VEC  = 11,
    parameter int              SRC_VEC0 = 64
) (
    input  logic [SRCW-1:0] src,
    output logic            dma_stage,
    output logic [1:0]      pri_cycles,
    output logic [VECW-1:0] vec_num
);
    logic [NSRC:0]         d_tab;
    logic [2*(NSRC+1)-1:0] p_tab;

    for (genvar g = 0; g < NSRC; g++) begin : g_tab
        assign d_tab[g]         = IRQ_SET[g] | DMA_SET[g];
        assign p_tab[2*g +: 2]  = IRQ_SET[g] ? 2'd3 : 2'd2;
    end
    assign d_tab[NSRC]            = 1'b0;
    assign p_tab[2*NSRC +: 2]     = 2'd2;

    always_comb begin
        dma_stage  = 1'b0;
        pri_cycles = 2'd2;
        for (int i = 0; i <= NSRC; i++) begin
            if (src == SRCW'(i)) begin
                dma_stage  = d_tab[i];
                pri_cycles = p_tab[2*i +: 2];
            end
        end
        if (src == SRCW'(NSRC)) vec_num = VECW'(NMI_VEC);
        else                    vec_num = VECW'(SRC_VEC0) + VECW'(src);
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              NSRC     = 4,
    parameter int              CNTW     = 16,
    parameter int              VECW     = 8,
    parameter logic [NSRC-1:0] IRQ_SET  = 4'b0011,
    parameter logic [NSRC-1:0] DMA_SET  = 4'b0100,
    parameter int              NMI_VEC  = 11,
    parameter int              SRC_VEC0 = 64,
    localparam int             SRCW     = $clog2(NSRC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_req,
    input  logic [NSRC-1:0]      src_req,
    input  logic [NSRC*LVLW-1:0] src_level,
    input  logic [LVLW-1:0]      sr_mask,
    input  logic [31:0]          sr_in,
    input  logic [31:0]          pc_in,
    input  logic [31:0]          sp_in,
    input  logic [31:0]          vbr_in,
    input  logic                 cpu_done,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [1:0]           mem_kind,
    output logic [31:0]          mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    input  logic                 mem_ready,
    output logic                 take,
    output logic [SRCW-1:0]      take_src,
    output logic                 busy,
    output logic [CNTW-1:0]      lat_cycles
);
    typedef struct packed {
        seq_state_e      st;
        logic [1:0]      pri_left;
        logic [SRCW-1:0] src;
        logic [VECW-1:0] vec;
        logic [31:0]     handler;
        logic [CNTW-1:0] lat;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic            pick_valid;
    logic [SRCW-1:0] pick_src;
    logic            cost_dma;
    logic [1:0]      cost_pri;
    logic [VECW-1:0] cost_vec;

    irq_entry_pick #(.NSRC(NSRC), .LVLW(LVLW), .SRCW(SRCW)) u_pick (
        .nmi_req    (nmi_req),
        .src_req    (src_req),
        .src_level  (src_level),
        .mask       (sr_mask),
        .pick_valid (pick_valid),
        .pick_src   (pick_src)
    );

    irq_entry_cost #(
        .NSRC(NSRC), .SRCW(SRCW), .VECW(VECW), .IRQ_SET(IRQ_SET),
        .DMA_SET(DMA_SET), .NMI_VEC(NMI_VEC), .SRC_VEC0(SRC_VEC0)
    ) u_cost (
        .src        (pick_src),
        .dma_stage  (cost_dma),
        .pri_cycles (cost_pri),
        .vec_num    (cost_vec)
    );

    always_comb begin
        r_d       = r_q;
        take      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_kind  = K_SR;
        mem_addr  = '0;
        mem_wdata = '0;

        if (r_q.st != ST_IDLE && r_q.st != ST_FET) r_d.lat = r_q.lat + 1'b1;

        case (r_q.st)
            ST_IDLE: begin
                if (pick_valid) begin
                    take         = 1'b1;
                    r_d.src      = pick_src;
                    r_d.vec      = cost_vec;
                    r_d.lat      = '0;
                    r_d.pri_left = cost_pri - 2'd1;
                    r_d.st       = cost_dma ? ST_DMA : ST_PRI;
                end
            end
            ST_DMA: r_d.st = ST_PRI;
            ST_PRI: begin
                if (r_q.pri_left != 2'd0) r_d.pri_left = r_q.pri_left - 2'd1;
                else                      r_d.st = cpu_done ? ST_E0 : ST_WAIT;
            end
            ST_WAIT: if (cpu_done) r_d.st = ST_E0;
            ST_E0:   r_d.st = ST_SRW;
            ST_SRW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_kind  = K_SR;
                mem_addr  = sp_in - 32'd4;
                mem_wdata = sr_in;
                if (mem_ready) r_d.st = ST_E1;
            end
            ST_E1:   r_d.st = ST_PCW;
            ST_PCW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_kind  = K_PC;
                mem_addr  = sp_in - 32'd8;
                mem_wdata = pc_in;
                if (mem_ready) r_d.st = ST_E2;
            end
            ST_E2:   r_d.st = ST_VRD;
            ST_VRD: begin
                mem_req  = 1'b1;
                mem_kind = K_VEC;
                mem_addr = vbr_in + {{(30-VECW){1'b0}}, r_q.vec, 2'b00};
                if (mem_ready) begin
                    r_d.handler = mem_rdata;
                    r_d.st      = ST_E3;
                end
            end
            ST_E3:   r_d.st = ST_E4;
            ST_E4:   r_d.st = ST_FET;
            ST_FET: begin
                mem_req  = 1'b1;
                mem_kind = K_FETCH;
                mem_addr = r_q.handler;
                if (mem_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.pri_left <= '0;
            r_q.src      <= '0;
            r_q.vec      <= '0;
            r_q.handler  <= '0;
            r_q.lat      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign take_src   = take ? pick_src : r_q.src;
    assign lat_cycles = r_q.lat;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int CNTW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [1:0]      mem_kind,
    input logic [31:0]     mem_addr,
    input logic [CNTW-1:0] lat_cycles
);
    a_r1_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r2_take_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !busy);

    a_r5_latency_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_kind == 2'd3) |-> (lat_cycles >= CNTW'(10)));

    a_r8_write_kinds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_we == (mem_kind == 2'd0 || mem_kind == 2'd1)));

    a_r9_idle_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_kind == 2'd3 && mem_ready) |=> !busy);

    a_r10_access_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_kind)));

    a_r11_lat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_kind == 2'd3) |=> $stable(lat_cycles));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.CNTW(CNTW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_kind   (mem_kind),
    .mem_addr   (mem_addr),
    .lat_cycles (lat_cycles)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    localparam int NSRC = 4;
    localparam int SRCW = $clog2(NSRC + 1);
    localparam int CNTW = 16;
    localparam logic [31:0] SP  = 32'h0000_8000;
    localparam logic [31:0] VBR = 32'h0001_0000;
    localparam logic [31:0] SRV = 32'h0000_00F0;
    localparam logic [31:0] PCV = 32'h1234_5678;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_req = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic [NSRC*4-1:0] src_level = '0;
    logic [3:0] sr_mask = '0;
    logic cpu_done = 1'b1;
    logic [31:0] mem_rdata = '0;
    logic mem_ready = 1'b0;
    logic mem_req, mem_we, take, busy;
    logic [1:0] mem_kind;
    logic [31:0] mem_addr, mem_wdata;
    logic [SRCW-1:0] take_src;
    logic [CNTW-1:0] lat_cycles;

    int checks = 0;
    int failures = 0;
    int last_lat = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .src_req(src_req),
        .src_level(src_level), .sr_mask(sr_mask), .sr_in(SRV), .pc_in(PCV),
        .sp_in(SP), .vbr_in(VBR), .cpu_done(cpu_done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_kind(mem_kind), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .take(take), .take_src(take_src), .busy(busy), .lat_cycles(lat_cycles)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] handler_of(input logic [31:0] a);
        return a + 32'h4000_0100;
    endfunction

    // class costs taken from R5/R6: sources 0,1 IRQ; source 2 DMA peripheral
    function automatic int d_of(input int s);
        return (s == 0 || s == 1 || s == 2) ? 1 : 0;
    endfunction
    function automatic int p_of(input int s);
        return (s == 0 || s == 1) ? 3 : 2;
    endfunction
    function automatic int vec_of(input int s);
        return (s == NSRC) ? 11 : 64 + s;
    endfunction

    task automatic drop_reqs();
        nmi_req = 1'b0;
        src_req = '0;
    endtask

    // requests already driven at this negedge by the caller
    task automatic run_entry(input string req, input int s, input int x,
                             input int m1, input int m2, input int m3, input int m4);
        int d, p, a, tot, explat;
        logic [31:0] vaddr;
        d = d_of(s); p = p_of(s); a = d + p + x;
        explat = a + 5 + m1 + m2 + m3;
        tot = explat + m4;
        vaddr = VBR + 32'(4 * vec_of(s));
        #1;
        chk(take == 1'b1, "R2", "take", take, 1);
        chk(int'(take_src) == s, req, "take_src winner", take_src, s);
        @(negedge clk);
        drop_reqs();
        for (int i = 0; i < tot; i++) begin
            bit ereq, ewe, erdy;
            int ekind, j;
            logic [31:0] eaddr, ewd;
            ereq = 0; ewe = 0; erdy = 0; ekind = 0; eaddr = '0; ewd = '0;
            j = i - a;
            if (j >= 1 && j < 1 + m1) begin
                ereq = 1; ewe = 1; ekind = 0; eaddr = SP - 4; ewd = SRV; erdy = (j == m1);
            end else if (j >= 2 + m1 && j < 2 + m1 + m2) begin
                ereq = 1; ewe = 1; ekind = 1; eaddr = SP - 8; ewd = PCV;
                erdy = (j == 1 + m1 + m2);
            end else if (j >= 3 + m1 + m2 && j < 3 + m1 + m2 + m3) begin
                ereq = 1; ekind = 2; eaddr = vaddr; erdy = (j == 2 + m1 + m2 + m3);
            end else if (i >= explat) begin
                ereq = 1; ekind = 3; eaddr = handler_of(vaddr); erdy = (i == tot - 1);
            end
            cpu_done  = !(i >= d + p - 1 && i <= d + p + x - 2);   // R7 stall window
            mem_ready = erdy;
            mem_rdata = handler_of(eaddr);
            #1;
            chk(busy == 1'b1, "R5", "busy in sequence", busy, 1);
            chk(take == 1'b0, "R2", "no take while busy", take, 0);
            chk(mem_req == ereq, req, $sformatf("mem_req cycle %0d", i), mem_req, ereq);
            if (ereq) begin
                string rq;
                rq = (ekind == 3) ? "R9" : "R8";
                chk(int'(mem_kind) == ekind, rq, "mem_kind", mem_kind, ekind);
                chk(mem_addr == eaddr, rq, "mem_addr", mem_addr, eaddr);
                chk(mem_we == ewe, rq, "mem_we", mem_we, ewe);
                if (ewe) chk(mem_wdata == ewd, "R8", "mem_wdata", mem_wdata, ewd);
            end
            if (i >= explat)
                chk(int'(lat_cycles) == explat, (p == 3) ? "R6" : "R5",
                    "lat_cycles at fetch", lat_cycles, explat);
            @(negedge clk);
        end
        mem_ready = 1'b0;
        cpu_done  = 1'b1;
        #1;
        chk(busy == 1'b0, "R9", "idle after fetch", busy, 0);
        chk(int'(lat_cycles) == explat, "R11", "lat held after fetch", lat_cycles, explat);
        last_lat = explat;
        @(negedge clk);
    endtask

    task automatic set_level(input int s, input int lvl);
        src_level[4*s +: 4] = 4'(lvl);
        src_req[s] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        chk(int'(lat_cycles) == 0, "R1", "lat in reset", lat_cycles, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(take == 1'b0 && busy == 1'b0, "R1", "idle after reset", busy, 0);
        @(negedge clk);

        // R3/R5: non-maskable alone, minimum 10
        nmi_req = 1'b1;
        run_entry("R3", NSRC, 0, 1, 1, 1, 1);
        // R6: IRQ source minimum 12
        set_level(0, 5);
        run_entry("R6", 0, 0, 1, 1, 1, 1);
        // R5: DMA-capable peripheral, 11
        set_level(2, 2);
        run_entry("R5", 2, 0, 1, 1, 1, 1);
        // R5: plain peripheral, 10
        set_level(3, 1);
        run_entry("R5", 3, 0, 1, 1, 1, 1);

        // R2: level equal to mask is ignored; lat keeps its value (R11)
        sr_mask = 4'd6;
        set_level(1, 6);
        set_level(3, 2);
        for (int k = 0; k < 5; k++) begin
            #1;
            chk(take == 1'b0, "R2", "masked take", take, 0);
            chk(busy == 1'b0 && mem_req == 1'b0, "R2", "masked stays idle", busy, 0);
            chk(int'(lat_cycles) == last_lat, "R11", "lat held while idle", lat_cycles, last_lat);
            @(negedge clk);
        end
        drop_reqs();
        sr_mask = 4'd0;

        // R4: tie goes to lowest index
        set_level(1, 7);
        set_level(2, 7);
        run_entry("R4", 1, 0, 1, 1, 1, 1);
        // R4: highest level wins
        set_level(0, 5);
        set_level(3, 9);
        run_entry("R4", 3, 0, 2, 1, 3, 1);
        // R3: non-maskable beats level 15
        sr_mask = 4'd14;
        set_level(3, 15);
        nmi_req = 1'b1;
        run_entry("R3", NSRC, 0, 1, 2, 1, 2);
        sr_mask = 4'd0;
        // R7: stall on cpu_done
        nmi_req = 1'b1;
        run_entry("R7", NSRC, 5, 1, 1, 1, 1);
        set_level(0, 3);
        run_entry("R7", 0, 1, 1, 1, 1, 1);

        // R5/R6/R10 with random wait states and stalls
        for (int n = 0; n < 12; n++) begin
            int s;
            s = int'($urandom_range(0, NSRC));
            if (s == NSRC) nmi_req = 1'b1;
            else set_level(s, int'($urandom_range(1, 15)));
            run_entry(s < 2 ? "R6" : "R5", s, int'($urandom_range(0, 6)),
                      int'($urandom_range(1, 4)), int'($urandom_range(1, 4)),
                      int'($urandom_range(1, 4)), int'($urandom_range(1, 4)));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule